// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Stop-Bit Error Trap

This block turns an asynchronous serial line back into bytes. A strobe arriving at a fixed multiple of the bit rate (eight by default) drives every timing decision. The line first crosses into the clock domain through a reset-to-idle synchronizer. A low level seen while the receiver is idle marks the start of a frame. Data bits are then sampled near their middles and assembled least significant bit first. Finally the stop position is examined.

A frame whose stop sample is high puts its byte into a small first-in first-out store. Its reader sees the oldest byte at all times and pops it with a read strobe. A low stop sample means a framing fault or a break. In that case the byte is thrown away, a sticky fault flag is raised, and the receiver refuses to look for a new start until the line has gone high again. A good byte that finds the store full is also thrown away, and it raises a second sticky flag. One clear input lowers both flags.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset `empty` is 1, `not_empty` is 0, and both `err_frame` and `err_overrun` are 0. The synchronized line resets to the idle level 1.
- R2: Counting from the first tick that sees the synchronized line low in idle, data bit 0 is sampled OVS+OVS/2-1 ticks later (11 at OVS=8). Each later bit is sampled OVS ticks after the one before it. The first bit received becomes bit 0 of `rd_data`.
- R3: When the stop sample one bit period after the last data bit is high, the byte enters the store. Bytes leave in arrival order: `rd_data` shows the oldest, and `rd_en` while `not_empty` removes it at the clock edge.
- R4: The store holds DEPTH bytes (8 by default). `empty` and `not_empty` are always complements, and DEPTH stored bytes raise no error.
- R5: When the stop sample is low (framing fault, or break with all bits low), no byte is stored and `err_frame` becomes 1.
- R6: After a low stop sample the receiver ignores the low line until it sees the line high on a tick. Only then does it accept a new start, so the frame that follows is received intact and no extra byte appears.
- R7: A good byte arriving while DEPTH bytes are stored is dropped, the stored bytes are unchanged, and `err_overrun` becomes 1.
- R8: Both error flags stay set until `err_clr` is high at a clock edge. If an error event and `err_clr` fall on the same edge, the flag ends up set.
- R9: `rd_en` while `empty` is ignored: `empty` stays 1 and the next byte received reads back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_x8 | input | 1 | One-cycle strobe at OVS times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_en | input | 1 | Pop the oldest stored byte |
| err_clr | input | 1 | Clear both sticky error flags |
| rd_data | output | DATA_W | Oldest stored byte |
| empty | output | 1 | Store holds no byte |
| not_empty | output | 1 | Store holds at least one byte |
| err_frame | output | 1 | Sticky: low stop sample seen |
| err_overrun | output | 1 | Sticky: good byte dropped because the store was full |

## Verification
The clear input and a fresh error event can fall on the same clock edge. This collision is provoked directly: the bench counts ticks from the start bit of a frame with a low stop bit and raises `err_clr` for exactly the cycle whose edge carries the stop sample. The flag must read 1 afterwards, because setting takes priority, and a later isolated clear must bring it to 0. Popping on an empty store is exercised in the same spirit. A bad frame followed by a long low line checks that the receiver does not start a frame early.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_STOP = 2'd2,
      ST_HOLD = 2'd3
   } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uart_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= {STAGES{RST_VAL}};
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
   import uart_rx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVS        = 8,
   parameter int FIRST_WAIT = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_s,
   output logic              push,
   output logic              frame_evt,
   output logic [DATA_W-1:0] data
);
   localparam int CNT_W = $clog2(FIRST_WAIT + 1);
   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bit_idx;
   logic [DATA_W-1:0] shreg;
   logic              sample;

   generate
      if (FIRST_WAIT < OVS) begin : g_bad_wait
         $error("uart_rx_deframer: FIRST_WAIT must be at least OVS");
      end
   endgenerate

   assign sample    = tick && (cnt == '0);
   assign push      = sample && (state == ST_STOP) && rx_s;
   assign frame_evt = sample && (state == ST_STOP) && !rx_s;
   assign data      = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         shreg   <= '0;
      end else if (tick) begin
         case (state)
            ST_IDLE: begin
               if (!rx_s) begin
                  state   <= ST_DATA;
                  cnt     <= CNT_W'(FIRST_WAIT - 1);
                  bit_idx <= '0;
               end
            end
            ST_DATA: begin
               if (cnt == '0) begin
                  shreg <= {rx_s, shreg[DATA_W-1:1]};
                  cnt   <= CNT_W'(OVS - 1);
                  if (bit_idx == BIT_W'(DATA_W - 1)) state <= ST_STOP;
                  else                               bit_idx <= bit_idx + 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_STOP: begin
               if (cnt == '0) state <= rx_s ? ST_IDLE : ST_HOLD;
               else           cnt   <= cnt - 1'b1;
            end
            default: begin
               if (rx_s) state <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       rd_en,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       full,
   output logic                       empty,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              wr_ok, rd_ok;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("uart_rx_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign wr_ok   = wr_en && !full;
   assign rd_ok   = rd_en && !empty;
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 8,
   parameter int DEPTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_x8,
   input  logic              rx_line,
   input  logic              rd_en,
   input  logic              err_clr,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              not_empty,
   output logic              err_frame,
   output logic              err_overrun
);
   localparam int FIRST_WAIT = OVS + OVS / 2 - 1;
   localparam int CNT_W      = $clog2(DEPTH + 1);

   logic              rx_s;
   logic              push_w;
   logic              frame_evt;
   logic              ovr_evt;
   logic              fifo_full;
   logic [DATA_W-1:0] byte_w;
   logic [CNT_W-1:0]  fifo_count;

   generate
      if (OVS < 4) begin : g_bad_ovs
         $error("uart_frame_rx: OVS must be at least 4");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("uart_frame_rx: DATA_W must be at least 2");
      end
   endgenerate

   uart_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_line),
      .q     (rx_s)
   );

   uart_rx_deframer #(.DATA_W(DATA_W), .OVS(OVS), .FIRST_WAIT(FIRST_WAIT)) u_deframe (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_x8),
      .rx_s      (rx_s),
      .push      (push_w),
      .frame_evt (frame_evt),
      .data      (byte_w)
   );

   uart_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_w),
      .wr_data (byte_w),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .full    (fifo_full),
      .empty   (empty),
      .count   (fifo_count)
   );

   assign not_empty = (fifo_count != '0);
   assign ovr_evt   = push_w && fifo_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
      end else begin
         if (frame_evt)    err_frame <= 1'b1;
         else if (err_clr) err_frame <= 1'b0;
         if (ovr_evt)      err_overrun <= 1'b1;
         else if (err_clr) err_overrun <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk #(
   parameter int DEPTH = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       rd_en,
   input logic                       err_clr,
   input logic                       empty,
   input logic                       not_empty,
   input logic                       err_frame,
   input logic                       err_overrun,
   input logic                       push,
   input logic                       frame_evt,
   input logic [$clog2(DEPTH+1)-1:0] count
);
   // R4: the two occupancy outputs never agree
   assert_occupancy_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      empty != not_empty);

   // R4: occupancy never exceeds the depth
   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= ($clog2(DEPTH+1))'(DEPTH));

   // R5: a rejected stop sample never stores a byte
   assert_no_push_on_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_evt |-> !push);

   // R5: a stop fault shows up on the flag one edge later
   assert_fault_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_evt |=> err_frame);

   // R7: a good byte into a full store raises overrun
   assert_overrun_on_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && count == ($clog2(DEPTH+1))'(DEPTH)) |=> err_overrun);

   // R8: flags persist without a clear
   assert_frame_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_frame && !err_clr) |=> err_frame);
   assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_overrun && !err_clr) |=> err_overrun);

   // R9: popping an empty store with no incoming byte leaves it empty
   assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en && !push) |=> empty);
endmodule

bind uart_frame_rx uart_frame_rx_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_en       (rd_en),
   .err_clr     (err_clr),
   .empty       (empty),
   .not_empty   (not_empty),
   .err_frame   (err_frame),
   .err_overrun (err_overrun),
   .push        (push_w),
   .frame_evt   (frame_evt),
   .count       (fifo_count)
);

// File: tb/test_uart_frame_rx.sv
module test_uart_frame_rx;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int OVS        = 8;
   localparam int DEPTH      = 8;

   logic       clk, rst_n, tick_x8, rx_line, rd_en, err_clr;
   logic [7:0] rd_data;
   logic       empty, not_empty, err_frame, err_overrun;

   int          checks = 0;
   int          errors = 0;
   int          tdiv   = 0;
   bit          done   = 0;
   logic [7:0]  exp_q[$];
   bit          exp_frame = 0;
   bit          exp_ovr   = 0;

   uart_frame_rx #(.DATA_W(8), .OVS(OVS), .DEPTH(DEPTH), .SYNC_STAGES(2)) i_uart_frame_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_x8     (tick_x8),
      .rx_line     (rx_line),
      .rd_en       (rd_en),
      .err_clr     (err_clr),
      .rd_data     (rd_data),
      .empty       (empty),
      .not_empty   (not_empty),
      .err_frame   (err_frame),
      .err_overrun (err_overrun)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   initial tick_x8 = 1'b0;
   always @(negedge clk) begin
      tdiv    <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
      tick_x8 <= (tdiv == TICK_DIV-1);
   end

   task automatic report();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // reference model of what one frame does to the store and flags
   function automatic void model_frame(input logic [7:0] b, input bit good);
      if (!good)                        exp_frame = 1;
      else if (exp_q.size() == DEPTH)   exp_ovr   = 1;
      else                              exp_q.push_back(b);
   endfunction

   task automatic wait_tick();
      do @(posedge clk); while (tick_x8 !== 1'b1);
      #1;
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) wait_tick();
   endtask

   task automatic send_frame(input logic [7:0] b, input bit good, input bit clr_at_stop);
      wait_tick();
      rx_line = 1'b0;
      wait_ticks(OVS);
      for (int i = 0; i < 8; i++) begin
         rx_line = b[i];
         wait_ticks(OVS);
      end
      rx_line = good;
      if (clr_at_stop) begin
         // stop sample lands on tick 76 from the start edge; line set at tick 72
         wait_ticks(3);
         @(negedge clk);
         while (tick_x8 !== 1'b1) @(negedge clk);
         err_clr = 1'b1;
         @(posedge clk); #1;
         err_clr = 1'b0;
         wait_ticks(4);
      end else begin
         wait_ticks(OVS);
      end
      if (!good) begin
         wait_ticks(OVS);
         rx_line = 1'b1;
         wait_ticks(OVS/2);
      end
      model_frame(b, good);
   endtask

   task automatic check_flags(input string req);
      @(negedge clk);
      check(err_frame == exp_frame, {req, " err_frame"}, err_frame, exp_frame);
      check(err_overrun == exp_ovr, {req, " err_overrun"}, err_overrun, exp_ovr);
   endtask

   task automatic drain(input string req);
      while (exp_q.size() > 0) begin
         @(negedge clk);
         check(not_empty == 1'b1, {req, " not_empty"}, not_empty, 1);
         check(rd_data == exp_q[0], {req, " rd_data"}, rd_data, exp_q[0]);
         rd_en = 1'b1;
         @(posedge clk); #1;
         rd_en = 1'b0;
         void'(exp_q.pop_front());
      end
      @(negedge clk);
      check(empty == 1'b1 && not_empty == 1'b0, {req, " empty after drain"}, empty, 1);
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      err_clr = 1'b1;
      @(posedge clk); #1;
      err_clr = 1'b0;
      exp_frame = 0;
      exp_ovr   = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 180000);
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      report();
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; rx_line = 1'b1; rd_en = 1'b0; err_clr = 1'b0;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      check(empty == 1'b1, "R1 empty", empty, 1);
      check(not_empty == 1'b0, "R1 not_empty", not_empty, 0);
      check(err_frame == 1'b0 && err_overrun == 1'b0, "R1 flags", {err_frame, err_overrun}, 0);

      // R9: pop on empty store is ignored
      rd_en = 1'b1;
      repeat (3) @(posedge clk);
      #1 rd_en = 1'b0;
      @(negedge clk);
      check(empty == 1'b1, "R9 empty after pop", empty, 1);
      send_frame(8'h3C, 1, 0);
      drain("R9");

      // R2 R3: directed bit patterns, LSB first, in order
      send_frame(8'hA5, 1, 0);
      send_frame(8'h01, 1, 0);
      send_frame(8'h80, 1, 0);
      send_frame(8'hFF, 1, 0);
      drain("R2 R3 directed");

      // R2 R3: random batches
      for (int r = 0; r < 6; r++) begin
         int n;
         n = $urandom_range(1, DEPTH);
         for (int k = 0; k < n; k++) send_frame(8'($urandom), 1, 0);
         drain("R3 random");
         check_flags("R3 random");
      end

      // R4: exactly DEPTH bytes, no overrun
      for (int k = 0; k < DEPTH; k++) send_frame(8'($urandom), 1, 0);
      check_flags("R4 full no error");
      drain("R4");

      // R7: one byte beyond depth is dropped
      for (int k = 0; k < DEPTH + 1; k++) send_frame(8'(k * 17 + 3), 1, 0);
      check_flags("R7 overrun");
      drain("R7 contents kept");

      // R8: sticky until cleared
      repeat (20) @(posedge clk);
      check_flags("R8 sticky");
      pulse_clear();
      check_flags("R8 cleared");

      // R5 R6: framing fault, then break, then a good byte
      send_frame(8'h96, 0, 0);
      check_flags("R5 framing");
      @(negedge clk);
      check(empty == 1'b1, "R5 no byte stored", empty, 1);
      send_frame(8'h00, 0, 0);
      check_flags("R5 break");
      send_frame(8'h5A, 1, 0);
      drain("R6 rearm");
      check_flags("R6 flags");

      // R8: clear on the same edge as a new fault leaves the flag set
      pulse_clear();
      check_flags("R8 clear alone");
      send_frame(8'h42, 0, 1);
      check_flags("R8 set wins over clear");
      pulse_clear();
      check_flags("R8 clear after collision");

      // mixed random good/bad frames
      for (int k = 0; k < 6; k++) begin
         bit g;
         g = ($urandom_range(0, 3) != 0);
         send_frame(8'($urandom), g, 0);
      end
      check_flags("R5 R6 mixed");
      drain("R6 mixed");

      report();
   end
endmodule